// File: doc/BRIEF.md
# Processor Utilisation Meter

This block tells how busy a processor core has been. Every elapsed core cycle arrives as a strobe. Each strobe is marked as useful work or as idle time. The block counts all strobes and idle strobes over a window of fixed length. When the window closes it computes the busy share as an unsigned 0.16 fixed-point value, where 0x10000 means fully busy. The value is rounded half-up to the nearest 1/65536 and clamped. It is then latched on the output and held until the next window closes.

The block also recognises a common idle loop on its own. The loop is a branch whose target is the branch itself, with a nop in its delay slot. When the retiring-instruction inputs show that nop in the delay slot, the core enters an idle mode. Every following cycle then counts as idle until the wake input ends the mode.

The quotient comes from a restoring divider that produces one bit per clock. A control machine has two states. In COUNT it accumulates cycles. The transition CLOSE (total reaches the window length while in COUNT) clears the counters, starts the divider and moves to DIVIDE. The transition FINISH (divider done while in DIVIDE) latches the rounded result, pulses the update strobe and returns to COUNT. The divider has three states. IDLE goes to RUN on its start input. RUN goes to DONE when its last quotient bit is produced. DONE returns to IDLE after one cycle.

Top module: `util_meter`

## Requirements
- R1: A window closes in the first cycle in COUNT with a total of at least WINDOW. In that cycle both counters restart, and a cycle strobe present in that same cycle counts as the first cycle of the next window.
- R2: A strobed cycle counts as idle when `cyc_idle` is high, or when idle mode is active, or when the detector fires in that cycle. The idle count never exceeds the total count.
- R3: The result is floor((floor((total-idle)*131072/total)+1)/2). Before the division a zero total is treated as 1 and the idle count is limited to the total.
- R4: The latched result stays within 0x00000..0x10000. A window with no idle cycle gives 0x10000, and an all-idle window gives 0x00000.
- R5: After reset `busy_frac` is 0 and `frac_upd` is low. `busy_frac` changes only in a cycle where `frac_upd` is high, and `frac_upd` is a one-cycle pulse.
- R6: The detector fires when `ins_valid` and `in_slot` are high, `ins_word` is 0x00000000 and `slot_target` equals `ins_pc` minus 4. From the next cycle, idle mode is active.
- R7: No idle mode starts for a nonzero word, a target that differs from `ins_pc`-4, or a nop with `in_slot` low.
- R8: `wake` clears idle mode at the next edge. When `wake` and a detection occur in the same cycle, `wake` wins.
- R9: Each closed window gives exactly one update. No window closes while a division is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One elapsed core cycle |
| cyc_idle | input | 1 | The strobed cycle is idle |
| wake | input | 1 | Leave detected idle mode |
| ins_valid | input | 1 | An instruction retires this cycle |
| ins_word | input | 32 | Retiring instruction word |
| ins_pc | input | AW | Address of the retiring instruction |
| in_slot | input | 1 | Retiring instruction sits in a branch delay slot |
| slot_target | input | AW | Target of the pending branch |
| busy_frac | output | 17 | Latched busy fraction, 0x10000 = fully busy |
| frac_upd | output | 1 | Pulse when busy_frac is reloaded |

## Verification
A window can close in the very cycle that brings a new cycle strobe. In that case the counter clear and the counting of the first cycle of the next window fall together. The bench provokes this with two back-to-back windows of continuous strobes and no gap between them, with idle cycles placed only in the second window. If the second window drops or double-counts that boundary strobe, it never closes or carries the wrong idle share. The bench therefore judges the case by the number of updates and by both latched fractions.

// File: rtl/util_pkg.sv
package util_pkg;
    localparam int FRAC_W     = 17;
    localparam int FRAC_SHIFT = 17;
    localparam logic [FRAC_W-1:0] FRAC_ONE = 17'h10000;

    typedef enum logic [0:0] {
        CT_COUNT,
        CT_DIVIDE
    } ctl_state_t;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_RUN,
        DV_DONE
    } div_state_t;
endpackage

// File: rtl/util_idle_detect.sv
module util_idle_detect #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [31:0]   ins_word,
    input  logic [AW-1:0] ins_pc,
    input  logic          in_slot,
    input  logic [AW-1:0] slot_target,
    input  logic          wake,
    output logic          hit,
    output logic          idle_mode
);
    localparam logic [AW-1:0] INSN_BYTES = AW'(4);

    logic [AW-1:0] branch_pc;

    always_comb begin
        branch_pc = ins_pc - INSN_BYTES;
        hit = ins_valid && in_slot && (ins_word == 32'h0) && (slot_target == branch_pc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_mode <= 1'b0;
        else if (wake)
            idle_mode <= 1'b0;
        else if (hit)
            idle_mode <= 1'b1;
    end

    assert_enter_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wake) |=> idle_mode);
    assert_wake_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !idle_mode);
endmodule

// File: rtl/util_window_counter.sv
module util_window_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tick_idle,
    input  logic             restart,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] idle
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic idle_step;

    always_comb idle_step = tick && tick_idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
            idle  <= '0;
        end else if (restart) begin
            total <= tick      ? ONE : '0;
            idle  <= idle_step ? ONE : '0;
        end else if (tick) begin
            total <= total + ONE;
            idle  <= idle_step ? idle + ONE : idle;
        end
    end

    assert_idle_le_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle <= total);
    assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (total <= ONE));
endmodule

// File: rtl/util_seq_divider.sv
module util_seq_divider
    import util_pkg::*;
#(
    parameter int NUM_W = 49,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CW = $clog2(NUM_W + 1);
    localparam logic [CW-1:0] STEPS = CW'(NUM_W);
    localparam logic [CW-1:0] LAST  = CW'(1);

    div_state_t st, st_nx;
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q, den_q;
    logic [CW-1:0]    cnt_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    always_comb begin
        trial = {rem_q, quo_q[NUM_W-1]};
        fits  = trial >= {1'b0, den_q};
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            DV_IDLE: if (start) st_nx = DV_RUN;
            DV_RUN:  if (cnt_q == LAST) st_nx = DV_DONE;
            DV_DONE: st_nx = DV_IDLE;
            default: st_nx = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= DV_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (st)
                DV_IDLE: if (start) begin
                    quo_q <= numer;
                    rem_q <= '0;
                    den_q <= denom;
                    cnt_q <= STEPS;
                end
                DV_RUN: begin
                    rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                    quo_q <= {quo_q[NUM_W-2:0], fits};
                    cnt_q <= cnt_q - LAST;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy = (st != DV_IDLE);
        done = (st == DV_DONE);
        quot = quo_q;
    end

    assert_start_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/util_meter.sv
module util_meter
    import util_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WINDOW = 20_000_000,
    parameter int AW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              cyc_idle,
    input  logic              wake,
    input  logic              ins_valid,
    input  logic [31:0]       ins_word,
    input  logic [AW-1:0]     ins_pc,
    input  logic              in_slot,
    input  logic [AW-1:0]     slot_target,
    output logic [FRAC_W-1:0] busy_frac,
    output logic              frac_upd
);
    localparam int NUM_W = CNT_W + FRAC_SHIFT;
    localparam logic [CNT_W-1:0] WIN_LEN = CNT_W'(WINDOW);

    ctl_state_t st, st_nx;

    logic             det_hit, idle_mode, idle_in, close;
    logic [CNT_W-1:0] total, idle, den, idl;
    logic [NUM_W-1:0] numer, quot;
    logic [NUM_W:0]   bumped;
    logic [NUM_W-1:0] rounded;
    logic [FRAC_W-1:0] clamped;
    logic             div_busy, div_done;

    util_idle_detect #(.AW(AW)) u_det (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
        .ins_pc(ins_pc), .in_slot(in_slot), .slot_target(slot_target),
        .wake(wake), .hit(det_hit), .idle_mode(idle_mode)
    );

    always_comb idle_in = cyc_idle | idle_mode | det_hit;

    util_window_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .tick_idle(idle_in),
        .restart(close), .total(total), .idle(idle)
    );

    always_comb begin
        close = (st == CT_COUNT) && (total >= WIN_LEN);
        den   = (total == '0) ? CNT_W'(1) : total;
        idl   = (idle > den) ? den : idle;
        numer = {den - idl, {FRAC_SHIFT{1'b0}}};
    end

    util_seq_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(close), .numer(numer), .denom(den),
        .busy(div_busy), .done(div_done), .quot(quot)
    );

    always_comb begin
        bumped  = {1'b0, quot} + (NUM_W+1)'(1);
        rounded = bumped[NUM_W:1];
        clamped = (rounded > NUM_W'(FRAC_ONE)) ? FRAC_ONE : rounded[FRAC_W-1:0];
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            CT_COUNT:  if (close)    st_nx = CT_DIVIDE;
            CT_DIVIDE: if (div_done) st_nx = CT_COUNT;
            default:   st_nx = CT_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CT_COUNT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_frac <= '0;
            frac_upd  <= 1'b0;
        end else begin
            frac_upd <= (st == CT_DIVIDE) && div_done;
            if ((st == CT_DIVIDE) && div_done)
                busy_frac <= clamped;
        end
    end

    assert_frac_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_frac <= FRAC_ONE);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frac_upd |-> $stable(busy_frac));
    assert_upd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frac_upd |=> !frac_upd);
    assert_no_close_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> (st == CT_DIVIDE));
endmodule

// File: tb/util_meter_test.sv
module util_meter_test;
    localparam int W = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0, cyc_idle = 1'b0, wake = 1'b0;
    logic        ins_valid = 1'b0, in_slot = 1'b0;
    logic [31:0] ins_word = '0, ins_pc = '0, slot_target = '0;
    logic [16:0] busy_frac;
    logic        frac_upd;

    int errors = 0, checks = 0, upd_count = 0;
    logic [16:0] got1, got2;

    localparam int unsigned IDLE_N [6] = '{0, 100, 1, 3, 50, 37};

    always #4 clk = ~clk;

    util_meter #(.CNT_W(32), .WINDOW(W), .AW(32)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cyc_idle(cyc_idle),
        .wake(wake), .ins_valid(ins_valid), .ins_word(ins_word), .ins_pc(ins_pc),
        .in_slot(in_slot), .slot_target(slot_target),
        .busy_frac(busy_frac), .frac_upd(frac_upd)
    );

    function automatic logic [16:0] expect_frac(input longint total, input longint idl);
        longint q;
        q = ((total - idl) * 131072) / total;
        q = (q + 1) / 2;
        if (q > 65536) q = 65536;
        return 17'(q);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic i);
        @(negedge clk);
        cyc_tick = t; cyc_idle = i;
    endtask

    task automatic quiet();
        @(negedge clk);
        cyc_tick = 0; cyc_idle = 0; wake = 0; ins_valid = 0; in_slot = 0;
        ins_word = '0;
    endtask

    task automatic wait_upd(output bit seen);
        seen = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (frac_upd) begin seen = 1; break; end
        end
    endtask

    task automatic retire(input logic [31:0] w, input logic [31:0] pc,
                          input logic slot, input logic [31:0] tgt, input logic wk);
        @(negedge clk);
        cyc_tick = 0; cyc_idle = 0;
        ins_valid = 1; ins_word = w; ins_pc = pc; in_slot = slot; slot_target = tgt; wake = wk;
        @(negedge clk);
        ins_valid = 0; in_slot = 0; wake = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        check(busy_frac == 0, "R5 reset value", busy_frac, 0);
        check(frac_upd == 0, "R5 reset strobe", frac_upd, 0);
        rst_n = 1;
        @(negedge clk);

        // R3 R4 R2: table of idle counts per window
        for (int v = 0; v < 6; v++) begin
            for (int c = 0; c < W; c++) step(1, c < int'(IDLE_N[v]));
            quiet();
            wait_upd(seen);
            check(seen, "R3 update seen", seen, 1);
            check(busy_frac == expect_frac(W, IDLE_N[v]), "R3 R4 R2 fraction",
                  busy_frac, expect_frac(W, IDLE_N[v]));
        end
        check(expect_frac(W, 0) == 17'h10000, "R4 full busy ref", expect_frac(W, 0), 17'h10000);

        // R5: partial window holds output
        for (int c = 0; c < 50; c++) step(1, 1);
        quiet();
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            if (frac_upd) begin seen = 0; end
        end
        check(busy_frac == expect_frac(W, IDLE_N[5]), "R5 hold between updates",
              busy_frac, expect_frac(W, IDLE_N[5]));
        for (int c = 0; c < 50; c++) step(1, 0);
        quiet();
        wait_upd(seen);
        check(busy_frac == expect_frac(W, 50), "R5 finished window", busy_frac, expect_frac(W, 50));

        // R1 R9: back-to-back windows, close coincides with a tick
        upd_count = 0;
        fork
            begin
                for (int c = 0; c < 2 * W; c++) step(1, (c >= W) && (c < W + 50));
                quiet();
            end
            begin
                for (int k = 0; k < 2 * W + 200; k++) begin
                    @(negedge clk);
                    if (frac_upd) begin
                        upd_count++;
                        if (upd_count == 1) got1 = busy_frac;
                        if (upd_count == 2) got2 = busy_frac;
                    end
                end
            end
        join
        check(upd_count == 2, "R9 one update per window", upd_count, 2);
        check(got1 == 17'h10000, "R1 first window", got1, 17'h10000);
        check(got2 == expect_frac(W, 50), "R1 boundary tick in next window", got2, expect_frac(W, 50));

        // R6 R8: detected idle loop, then wake
        for (int c = 0; c < 30; c++) step(1, 0);
        retire(32'h0, 32'h0000_1004, 1, 32'h0000_1000, 0);
        for (int c = 0; c < 20; c++) step(1, 0);
        retire(32'h0000_0021, 32'h0000_2000, 0, 32'h0, 1);
        for (int c = 0; c < 50; c++) step(1, 0);
        quiet();
        wait_upd(seen);
        check(busy_frac == expect_frac(W, 20), "R6 R8 detect then wake", busy_frac, expect_frac(W, 20));

        // R7: near misses leave cycles busy
        for (int c = 0; c < 40; c++) step(1, 0);
        retire(32'h0, 32'h0000_1004, 1, 32'h0000_1008, 0);
        retire(32'h0000_0040, 32'h0000_1004, 1, 32'h0000_1000, 0);
        retire(32'h0, 32'h0000_1004, 0, 32'h0000_1000, 0);
        for (int c = 0; c < 60; c++) step(1, 0);
        quiet();
        wait_upd(seen);
        check(busy_frac == 17'h10000, "R7 near misses ignored", busy_frac, 17'h10000);

        // R8: wake and detection together, wake wins
        retire(32'h0, 32'h0000_3004, 1, 32'h0000_3000, 1);
        for (int c = 0; c < W; c++) step(1, 0);
        quiet();
        wait_upd(seen);
        check(busy_frac == 17'h10000, "R8 wake beats detection", busy_frac, 17'h10000);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule